// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Register

This block keeps, for up to four CPUs, two pending vectors. One holds inter-processor interrupts (IPIs) and the other holds interval-timer interrupts, with one bit per CPU. Each pending bit drives a level output of its own, so every CPU sees an IPI line and a timer line. These two levels are kept apart from any device interrupt level. CPUs post and retire interrupts through a shared 64-bit register port. A periodic tick input from an external timer posts a timer interrupt to every present CPU.

The port offers a combined register and three dedicated registers. A single write to the combined register can request IPIs, clear IPIs and clear timer interrupts at once. A read of the combined register returns the identity of the CPU doing the read, together with both pending vectors. The dedicated registers read or clear one vector at a time by CPU mask, or request IPIs by CPU mask. The parameter `NUM_CPUS` (1 to 4) sets how many CPUs are present. Mask bits that belong to absent CPUs have no effect.

The block registers a one-cycle warning pulse for redundant IPI operations and a one-cycle error pulse for a dedicated-register write whose mask selects no present CPU. Both pulses appear in the cycle after the offending write.

Top module: `ipi_timer_irq_reg`

## Requirements
- R1: After reset, both pending vectors are zero. All `ipiIrq` and `timerIrq` outputs are low, and `warnPulse` and `errPulse` are low.
- R2: A write to the combined register (`regSel`=0) with bits [15:12] set posts an IPI to each CPU whose bit is set. The matching `ipiIrq` bit is high from the next cycle.
- R3: In one combined write, bits [11:8] clear pending IPIs and bits [7:4] clear pending timer interrupts, for the CPUs whose bits are set. All three fields act in the same write. When the same CPU is both requested and cleared in one write, its IPI ends up clear.
- R4: Requesting an IPI for a CPU that already has one pending leaves the state unchanged. Clearing an IPI for a CPU that has none pending and none requested in the same write also leaves the state unchanged. Either case raises `warnPulse` for one cycle after the write.
- R5: A `timerTick` pulse sets the timer pending bit of every present CPU. `timerIrq` follows from the next cycle.
- R6: If a tick and a timer clear for the same CPU fall in the same cycle, the tick wins and the bit stays set.
- R7: A read of the combined register returns `cpuId` in bits [1:0], the timer pending vector in bits [7:4] and the IPI pending vector in bits [11:8]. All other bits read as zero.
- R8: The dedicated registers behave as follows:
  - `regSel`=1 reads the IPI vector in bits [3:0], and a write clears the IPIs whose mask bits in [3:0] are set.
  - `regSel`=2 does the same for the timer vector.
  - `regSel`=3 requests IPIs from the mask in [3:0] and reads as zero.
  - Select values 4 to 7 read as zero, and writes to them are ignored.
- R9: A write to `regSel` 1, 2 or 3 whose mask in [3:0] selects no present CPU changes no state and raises `errPulse` for one cycle after the write.
- R10: Mask bits for CPUs with index at or above `NUM_CPUS` are ignored. Those CPUs' `ipiIrq` and `timerIrq` bits stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Register select: 0 combined, 1 IPI status/clear, 2 timer status/clear, 3 IPI request |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 64 | Write data |
| cpuId | input | 2 | Identity of the accessing CPU |
| rdData | output | 64 | Read data of the selected register (combinational) |
| timerTick | input | 1 | One-cycle periodic timer tick |
| ipiIrq | output | 4 | Per-CPU IPI level |
| timerIrq | output | 4 | Per-CPU timer interrupt level |
| warnPulse | output | 1 | Redundant IPI request or clear in the previous cycle |
| errPulse | output | 1 | Dedicated write with an empty mask in the previous cycle |

## Verification
A timer tick and a register write that clears a timer bit can fall in the same cycle. So can an IPI request and an IPI clear for the same CPU inside one combined write. The bench provokes both races directly:
- it asserts `timerTick` in the same cycle as a dedicated timer-clear write, then as a combined write whose timer-clear field hits a pending CPU;
- it issues one combined write whose request and clear fields name the same CPU.

The results are judged against a bench model built from R3 and R6: the timer bit must stay set, and the doubly-named IPI must end up clear. A random phase then mixes ticks and writes of every kind.

// File: rtl/ipitmr_pkg.sv
package ipitmr_pkg;

  localparam int MAX_CPUS   = 4;
  localparam int DATA_W     = 64;
  localparam int SEL_W      = 3;
  localparam int ID_W       = 2;

  // Field positions of the combined register (write and read)
  localparam int REQ_LSB    = 12;
  localparam int IPI_LSB    = 8;
  localparam int TMR_LSB    = 4;
  localparam int ID_LSB     = 0;
  localparam int FIELD_TOP  = REQ_LSB + MAX_CPUS;

  typedef enum logic [SEL_W-1:0] {
    SEL_MISC   = 3'd0,
    SEL_IPI    = 3'd1,
    SEL_TMR    = 3'd2,
    SEL_REQ    = 3'd3
  } regSel_e;

  typedef logic [MAX_CPUS-1:0] cpuMask_t;

  // Strobes from control to datapath, all masks already limited to present CPUs
  typedef struct packed {
    cpuMask_t ipiSet;
    cpuMask_t ipiClr;
    cpuMask_t tmrClr;
    logic     tick;
    logic     zeroMask;
  } strobe_t;

endpackage

// File: rtl/ipitmr_ctrl.sv
module ipitmr_ctrl
  import ipitmr_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerTick,
  output strobe_t           strb
);

  localparam cpuMask_t PRESENT = cpuMask_t'((1 << NUM_CPUS) - 1);

  cpuMask_t lowMask;
  cpuMask_t reqField;
  cpuMask_t ipiField;
  cpuMask_t tmrField;
  logic     unusedHi;

  // Per-CPU field extraction, limited to present CPUs (R10)
  for (genvar gi = 0; gi < MAX_CPUS; gi++) begin : g_field
    if (gi < NUM_CPUS) begin : g_on
      assign lowMask[gi]  = wrData[gi];
      assign reqField[gi] = wrData[REQ_LSB + gi];
      assign ipiField[gi] = wrData[IPI_LSB + gi];
      assign tmrField[gi] = wrData[TMR_LSB + gi];
    end else begin : g_off
      assign lowMask[gi]  = 1'b0;
      assign reqField[gi] = 1'b0;
      assign ipiField[gi] = 1'b0;
      assign tmrField[gi] = 1'b0;
    end
  end

  assign unusedHi = ^{wrData[DATA_W-1:FIELD_TOP], PRESENT};

  always_comb begin
    strb      = '0;
    strb.tick = timerTick;
    if (wrEn) begin
      case (regSel_e'(regSel))
        SEL_MISC: begin
          strb.ipiSet = reqField;
          strb.ipiClr = ipiField;
          strb.tmrClr = tmrField;
        end
        SEL_IPI: begin
          strb.ipiClr   = lowMask;
          strb.zeroMask = (lowMask == '0);
        end
        SEL_TMR: begin
          strb.tmrClr   = lowMask;
          strb.zeroMask = (lowMask == '0);
        end
        SEL_REQ: begin
          strb.ipiSet   = lowMask;
          strb.zeroMask = (lowMask == '0);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ipitmr_dp.sv
module ipitmr_dp
  import ipitmr_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ID_W-1:0]   cpuId,
  output logic [DATA_W-1:0] rdData,
  output cpuMask_t          ipiIrq,
  output cpuMask_t          timerIrq,
  output logic              warnPulse,
  output logic              errPulse
);

  localparam cpuMask_t PRESENT = cpuMask_t'((1 << NUM_CPUS) - 1);

  cpuMask_t ipiPend, tmrPend;
  cpuMask_t ipiNext, tmrNext;
  logic     warnNext;

  // A clear in the same write as a request wins (R3); a tick beats a timer clear (R6)
  always_comb begin
    ipiNext  = (ipiPend | strb.ipiSet) & ~strb.ipiClr;
    tmrNext  = (tmrPend & ~strb.tmrClr) | (strb.tick ? PRESENT : '0);
    warnNext = |(strb.ipiSet & ipiPend) |
               |(strb.ipiClr & ~(ipiPend | strb.ipiSet));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ipiPend   <= '0;
      tmrPend   <= '0;
      warnPulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      ipiPend   <= ipiNext & PRESENT;
      tmrPend   <= tmrNext & PRESENT;
      warnPulse <= warnNext;
      errPulse  <= strb.zeroMask;
    end
  end

  assign ipiIrq   = ipiPend;
  assign timerIrq = tmrPend;

  // Register read mux (R7, R8)
  always_comb begin
    rdData = '0;
    case (regSel_e'(regSel))
      SEL_MISC: begin
        rdData[ID_LSB +: ID_W]      = cpuId;
        rdData[TMR_LSB +: MAX_CPUS] = tmrPend;
        rdData[IPI_LSB +: MAX_CPUS] = ipiPend;
      end
      SEL_IPI: rdData[MAX_CPUS-1:0] = ipiPend;
      SEL_TMR: rdData[MAX_CPUS-1:0] = tmrPend;
      default: rdData = '0;
    endcase
  end

  // R2: every requested, not simultaneously cleared CPU is pending next cycle
  a_r2_request_posts: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((ipiPend & $past(strb.ipiSet & ~strb.ipiClr)) ==
              $past(strb.ipiSet & ~strb.ipiClr)));

  // R3: a cleared CPU is not pending next cycle
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((ipiPend & $past(strb.ipiClr)) == '0));

  // R5 / R6: after a tick every present CPU has its timer bit set
  a_r6_tick_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> (timerIrq == PRESENT));

  // R9: an error pulse follows a write that changed nothing
  a_r9_err_no_change: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($stable(ipiIrq) && ($stable(timerIrq) || $past(strb.tick))));

  // R10: absent CPUs never signal
  a_r10_absent_low: assert property (@(posedge clk) disable iff (!rstN)
    ((ipiIrq | timerIrq) & ~PRESENT) == '0);

endmodule

// File: rtl/ipi_timer_irq_reg.sv
module ipi_timer_irq_reg
  import ipitmr_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              wrEn,
  input  logic [63:0]       wrData,
  input  logic [1:0]        cpuId,
  output logic [63:0]       rdData,
  input  logic              timerTick,
  output logic [3:0]        ipiIrq,
  output logic [3:0]        timerIrq,
  output logic              warnPulse,
  output logic              errPulse
);

  strobe_t strb;

  ipitmr_ctrl #(.NUM_CPUS(NUM_CPUS)) i_ctrl (
    .wrEn      (wrEn),
    .regSel    (regSel),
    .wrData    (wrData),
    .timerTick (timerTick),
    .strb      (strb)
  );

  ipitmr_dp #(.NUM_CPUS(NUM_CPUS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regSel    (regSel),
    .cpuId     (cpuId),
    .rdData    (rdData),
    .ipiIrq    (ipiIrq),
    .timerIrq  (timerIrq),
    .warnPulse (warnPulse),
    .errPulse  (errPulse)
  );

endmodule

// File: tb/test_ipi_timer_irq_reg.sv
`timescale 1ns/1ps
module test_ipi_timer_irq_reg;

  localparam int NCPU = 3;
  localparam logic [3:0] P = 4'b0111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [1:0]  cpuId = '0;
  logic [63:0] rdData;
  logic        timerTick = 1'b0;
  logic [3:0]  ipiIrq, timerIrq;
  logic        warnPulse, errPulse;

  int tests = 0;
  int fails = 0;

  logic [3:0] mIpi = '0, mTmr = '0;
  logic       mWarn = 1'b0, mErr = 1'b0;

  always #4 clk = ~clk;

  ipi_timer_irq_reg #(.NUM_CPUS(NCPU)) i_ipi_timer_irq_reg (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .cpuId(cpuId), .rdData(rdData), .timerTick(timerTick), .ipiIrq(ipiIrq),
    .timerIrq(timerIrq), .warnPulse(warnPulse), .errPulse(errPulse)
  );

  task automatic checkOuts(input string tag);
    tests++;
    if (ipiIrq !== mIpi || timerIrq !== mTmr || warnPulse !== mWarn || errPulse !== mErr) begin
      fails++;
      $display("FAIL %s: ipi/tmr/warn/err = %b/%b/%b/%b expected %b/%b/%b/%b",
               tag, ipiIrq, timerIrq, warnPulse, errPulse, mIpi, mTmr, mWarn, mErr);
    end
  endtask

  // One cycle of stimulus with the model updated from the requirements
  task automatic step(input bit doWr, input logic [2:0] sel, input logic [63:0] d,
                      input bit doTick, input string tag);
    logic [3:0] req, ci, ct;
    req = '0; ci = '0; ct = '0; mErr = 1'b0;
    if (doWr) begin
      case (sel)
        3'd0: begin req = d[15:12] & P; ci = d[11:8] & P; ct = d[7:4] & P; end
        3'd1: begin ci = d[3:0] & P; mErr = (ci == 0); end
        3'd2: begin ct = d[3:0] & P; mErr = (ct == 0); end
        3'd3: begin req = d[3:0] & P; mErr = (req == 0); end
        default: ;
      endcase
    end
    mWarn = ((req & mIpi) != 0) || ((ci & ~(mIpi | req)) != 0);
    mIpi  = (mIpi | req) & ~ci;
    mTmr  = (mTmr & ~ct) | (doTick ? P : 4'b0);
    @(negedge clk);
    wrEn = doWr; regSel = sel; wrData = d; timerTick = doTick;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; timerTick = 1'b0;
    checkOuts(tag);
  endtask

  task automatic checkRead(input logic [2:0] sel, input logic [1:0] id,
                           input logic [63:0] exp, input string tag);
    @(negedge clk);
    regSel = sel; cpuId = id;
    #1;
    tests++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%h expected %h", tag, rdData, exp);
    end
  endtask

  task automatic t_reset;
    checkOuts("R1 reset");
    checkRead(3'd0, 2'd2, 64'h2, "R1 R7 reset read");
  endtask

  task automatic t_request;
    step(1, 3'd0, 64'h3000, 0, "R2 combined request cpus 0,1");
  endtask

  task automatic t_redundant;
    step(1, 3'd0, 64'h1000, 0, "R4 request already pending");
    step(1, 3'd0, 64'h0400, 0, "R4 clear not pending");
    step(1, 3'd1, 64'h4, 0, "R4 dedicated clear not pending");
  endtask

  task automatic t_combined;
    step(0, 3'd0, 64'h0, 1, "R5 tick posts all");
    // request cpu2 and cpu1, clear ipi cpu0 and cpu1, clear timer cpu1
    step(1, 3'd0, 64'h6320, 0, "R3 three fields in one write");
  endtask

  task automatic t_readLayout;
    checkRead(3'd0, 2'd1, {52'h0, mIpi, mTmr, 4'h1}, "R7 combined layout");
    checkRead(3'd1, 2'd0, {60'h0, mIpi}, "R8 ipi status");
    checkRead(3'd2, 2'd0, {60'h0, mTmr}, "R8 timer status");
    checkRead(3'd3, 2'd0, 64'h0, "R8 request reads zero");
    checkRead(3'd5, 2'd3, 64'h0, "R8 unused select reads zero");
  endtask

  task automatic t_dedicated;
    step(1, 3'd3, 64'h1, 0, "R8 dedicated request");
    step(1, 3'd1, 64'h4, 0, "R8 dedicated ipi clear");
    step(1, 3'd2, 64'h1, 0, "R8 dedicated timer clear");
    step(1, 3'd6, 64'hFFFF, 0, "R8 write to unused select ignored");
    checkRead(3'd1, 2'd0, {60'h0, mIpi}, "R8 ipi after ops");
  endtask

  task automatic t_zeroMask;
    step(1, 3'd1, 64'hF0, 0, "R9 zero ipi-clear mask");
    step(1, 3'd3, 64'h0, 0, "R9 zero request mask");
    step(1, 3'd2, 64'h8, 0, "R9 R10 absent-only mask");
  endtask

  task automatic t_race;
    step(0, 3'd0, 64'h0, 1, "R5 tick");
    step(1, 3'd2, 64'h1, 1, "R6 tick beats dedicated timer clear");
    step(1, 3'd0, 64'h0070, 1, "R6 tick beats combined timer clear");
  endtask

  task automatic t_absent;
    step(1, 3'd0, 64'h8000, 0, "R10 absent request ignored");
    step(1, 3'd3, 64'hF, 0, "R10 mask with absent bit");
    step(0, 3'd0, 64'h0, 1, "R10 tick leaves absent low");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [2:0]  s;
      logic [63:0] d;
      s = 3'($urandom_range(0, 4));
      d = {$urandom, $urandom};
      step($urandom_range(0, 3) != 0, s, d, $urandom_range(0, 4) == 0, "R3 R4 R6 random mix");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_request();
    t_redundant();
    t_combined();
    t_readLayout();
    t_dedicated();
    t_zeroMask();
    t_race();
    t_absent();
    t_random();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule